// File: doc/BRIEF.md
# DDR controller operating-state machine

This block is the operating-state sequencer of a DRAM controller, reduced to what software sees. Software writes a 3-bit command code; the block replies through an 8-bit status word. Each accepted command moves the machine out of a stable state into a request state. It stays there for a parameterised number of cycles, then settles in the target stable state. Commands that are not legal in the current state are dropped and leave the status unchanged.

Low power can be entered two ways. Software can write a sleep command, or a hardware idle input can request it. The status word records which source caused the entry. An entry caused by the idle input cannot be ended by a software wakeup; it ends when the idle input drops. On the way out of low power, the exit request state holds until the PHY reports that its DLL has locked. The access-ready output is high only in the access state while the lock is present.

Top module: `ddrc_opstate`

## Requirements
- R1: After reset, the status word reads 0x00 (memory-init state, trigger field 0) and `access_ready_o` is low.
- R2: Status bits [2:0] hold the state: 0 memory-init, 1 config, 2 config-request, 3 access, 4 access-request, 5 low-power, 6 low-power-entry-request, 7 low-power-exit-request. Bits [6:4] hold the low-power trigger. Bits 3 and 7 always read 0.
- R3: In memory-init, command code 1 (configure) moves the state to config-request and then to config.
- R4: In config, command code 2 (go) moves the state to access-request and then to access.
- R5: In access, command code 3 (sleep) moves the state to low-power-entry-request and then to low-power. The trigger field becomes 2. This holds even if the idle input is high in the same cycle.
- R6: In access, with no sleep command written, a high `hw_idle_i` starts low-power entry and sets the trigger field to 1.
- R7: In low-power with a trigger other than 1, command code 4 (wakeup) moves the state to low-power-exit-request and then to access. The trigger field clears to 0 when access is reached.
- R8: In low-power with trigger 1, the wakeup command is ignored. Deassertion of `hw_idle_i` starts the exit instead.
- R9: The exit request state holds for as long as `dll_lock_i` is low. `access_ready_o` is high only in the access state with `dll_lock_i` high.
- R10: Command code 0 and codes 5 to 7 are ignored in every state. So are commands not legal in the current stable state, and every command written during a request state.
- R11: Each request state is shown for exactly `LAT` cycles before the target state appears, provided the DLL lock is present for an exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_i | input | 3 | Command code |
| hw_idle_i | input | 1 | Hardware idle request for low-power entry |
| dll_lock_i | input | 1 | PHY DLL lock indication |
| stat_o | output | 8 | Status word: state [2:0], trigger [6:4] |
| access_ready_o | output | 1 | Access state reached and DLL locked |

## Verification
All eight command codes are written in each of five settled conditions: memory-init, config, access, low-power entered by software, and low-power entered by the idle input. This separates the one legal transition per state from every ignored code, and it separates the two low-power trigger sources under the same wakeup write. For each accepted command, the time spent in the request state is measured, which checks the latency. Directed runs then cover the rest. A command written during a request state checks that mid-transition writes are dropped. Sleep and idle in the same cycle checks that software wins the trigger field. Holding the DLL lock low across a wakeup checks the exit hold and the ready output. A round trip through idle entry and exit checks the trigger clear.

// File: rtl/ddrc_opstate_pkg.sv
package ddrc_opstate_pkg;

  typedef enum logic [2:0] {
    ST_INIT_MEM     = 3'd0,
    ST_CONFIG       = 3'd1,
    ST_CONFIG_REQ   = 3'd2,
    ST_ACCESS       = 3'd3,
    ST_ACCESS_REQ   = 3'd4,
    ST_LOW_POWER    = 3'd5,
    ST_LP_ENTER_REQ = 3'd6,
    ST_LP_EXIT_REQ  = 3'd7
  } op_state_e;

  localparam logic [2:0] CMD_INIT   = 3'd0;
  localparam logic [2:0] CMD_CFG    = 3'd1;
  localparam logic [2:0] CMD_GO     = 3'd2;
  localparam logic [2:0] CMD_SLEEP  = 3'd3;
  localparam logic [2:0] CMD_WAKEUP = 3'd4;

  localparam logic [2:0] TRIG_NONE = 3'd0;
  localparam logic [2:0] TRIG_HW   = 3'd1;
  localparam logic [2:0] TRIG_SW   = 3'd2;

  // True for the four transient states.
  function automatic logic is_request(op_state_e s);
    return (s == ST_CONFIG_REQ) || (s == ST_ACCESS_REQ) ||
           (s == ST_LP_ENTER_REQ) || (s == ST_LP_EXIT_REQ);
  endfunction

  // Stable state that a request state resolves into.
  function automatic op_state_e settle_of(op_state_e s);
    case (s)
      ST_CONFIG_REQ:   return ST_CONFIG;
      ST_ACCESS_REQ:   return ST_ACCESS;
      ST_LP_ENTER_REQ: return ST_LOW_POWER;
      ST_LP_EXIT_REQ:  return ST_ACCESS;
      default:         return s;
    endcase
  endfunction

  // Status word layout: trigger in [6:4], state in [2:0].
  function automatic logic [7:0] pack_status(op_state_e s, logic [2:0] trig);
    return {1'b0, trig, 1'b0, s};
  endfunction

endpackage

// File: rtl/ddrc_cmd_decode.sv
module ddrc_cmd_decode
  import ddrc_opstate_pkg::*;
(
  input  op_state_e  state_i,
  input  logic [2:0] trig_i,
  input  logic       cmd_wr_i,
  input  logic [2:0] cmd_i,
  input  logic       hw_idle_i,
  output logic       start_o,
  output op_state_e  req_state_o,
  output logic [2:0] trig_o
);

  logic wr_cfg, wr_go, wr_sleep, wr_wake;

  assign wr_cfg   = cmd_wr_i && (cmd_i == CMD_CFG);
  assign wr_go    = cmd_wr_i && (cmd_i == CMD_GO);
  assign wr_sleep = cmd_wr_i && (cmd_i == CMD_SLEEP);
  assign wr_wake  = cmd_wr_i && (cmd_i == CMD_WAKEUP);

  always_comb begin
    start_o     = 1'b0;
    req_state_o = state_i;
    trig_o      = trig_i;
    case (state_i)
      ST_INIT_MEM: begin
        if (wr_cfg) begin
          start_o     = 1'b1;
          req_state_o = ST_CONFIG_REQ;
        end
      end
      ST_CONFIG: begin
        if (wr_go) begin
          start_o     = 1'b1;
          req_state_o = ST_ACCESS_REQ;
        end
      end
      ST_ACCESS: begin
        if (wr_sleep) begin
          start_o     = 1'b1;
          req_state_o = ST_LP_ENTER_REQ;
          trig_o      = TRIG_SW;
        end else if (hw_idle_i) begin
          start_o     = 1'b1;
          req_state_o = ST_LP_ENTER_REQ;
          trig_o      = TRIG_HW;
        end
      end
      ST_LOW_POWER: begin
        if (trig_i == TRIG_HW) begin
          if (!hw_idle_i) begin
            start_o     = 1'b1;
            req_state_o = ST_LP_EXIT_REQ;
          end
        end else if (wr_wake) begin
          start_o     = 1'b1;
          req_state_o = ST_LP_EXIT_REQ;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddrc_dwell_timer.sv
module ddrc_dwell_timer #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic elapsed_o
);

  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (load_i)         cnt <= CW'(LAT - 1);
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign elapsed_o = (cnt == '0);

endmodule

// File: rtl/ddrc_opstate.sv
module ddrc_opstate
  import ddrc_opstate_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr_i,
  input  logic [2:0] cmd_i,
  input  logic       hw_idle_i,
  input  logic       dll_lock_i,
  output logic [7:0] stat_o,
  output logic       access_ready_o
);

  op_state_e  state_q;
  logic [2:0] trig_q;

  op_state_e  req_state;
  logic [2:0] trig_next;
  logic       start_evt;
  logic       elapsed;
  logic       in_req;
  logic       settle_evt;

  ddrc_cmd_decode u_decode (
    .state_i     (state_q),
    .trig_i      (trig_q),
    .cmd_wr_i    (cmd_wr_i),
    .cmd_i       (cmd_i),
    .hw_idle_i   (hw_idle_i),
    .start_o     (start_evt),
    .req_state_o (req_state),
    .trig_o      (trig_next)
  );

  ddrc_dwell_timer #(.LAT(LAT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (start_evt),
    .elapsed_o (elapsed)
  );

  assign in_req     = is_request(state_q);
  assign settle_evt = in_req && elapsed &&
                      ((state_q != ST_LP_EXIT_REQ) || dll_lock_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_INIT_MEM;
      trig_q  <= TRIG_NONE;
    end else if (start_evt) begin
      state_q <= req_state;
      trig_q  <= trig_next;
    end else if (settle_evt) begin
      state_q <= settle_of(state_q);
      if (state_q == ST_LP_EXIT_REQ) trig_q <= TRIG_NONE;
    end
  end

  assign stat_o         = pack_status(state_q, trig_q);
  assign access_ready_o = (state_q == ST_ACCESS) && dll_lock_i;

endmodule

// File: rtl/ddrc_opstate_chk.sv
module ddrc_opstate_chk
  import ddrc_opstate_pkg::*;
#(
  parameter int LAT = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr_i,
  input logic [2:0] cmd_i,
  input logic       hw_idle_i,
  input logic       dll_lock_i,
  input logic [7:0] stat_o,
  input logic       access_ready_o,
  input logic       in_req,
  input logic       settle_evt
);

  logic [2:0] st;
  logic [2:0] tg;
  logic [31:0] dwell;

  assign st = stat_o[2:0];
  assign tg = stat_o[6:4];

  always_ff @(posedge clk) begin
    if (!rst_n)                     dwell <= '0;
    else if (!in_req)               dwell <= '0;
    else if (dwell != 32'hFFFF_FFFF) dwell <= dwell + 1;
  end

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[3] == 1'b0) && (stat_o[7] == 1'b0)); // R2

  AST_INIT_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INIT_MEM && cmd_wr_i && cmd_i != CMD_CFG) |=> (st == ST_INIT_MEM)); // R10

  AST_SLEEP_SW_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACCESS && cmd_wr_i && cmd_i == CMD_SLEEP) |=>
    (st == ST_LP_ENTER_REQ && tg == TRIG_SW)); // R5

  AST_HW_WAKE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOW_POWER && tg == TRIG_HW && hw_idle_i) |=> (st == ST_LOW_POWER)); // R8

  AST_EXIT_WAITS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LP_EXIT_REQ && !dll_lock_i) |=> (st == ST_LP_EXIT_REQ)); // R9

  AST_READY_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    access_ready_o |-> (st == ST_ACCESS)); // R9

  AST_DWELL_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    settle_evt |-> (dwell + 32'd1 >= 32'(LAT))); // R11

  AST_LOW_POWER_TRIG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOW_POWER) |-> (tg != TRIG_NONE)); // R6

endmodule

bind ddrc_opstate ddrc_opstate_chk #(.LAT(LAT)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_wr_i       (cmd_wr_i),
  .cmd_i          (cmd_i),
  .hw_idle_i      (hw_idle_i),
  .dll_lock_i     (dll_lock_i),
  .stat_o         (stat_o),
  .access_ready_o (access_ready_o),
  .in_req         (in_req),
  .settle_evt     (settle_evt)
);

// File: tb/ddrc_opstate_bench.sv
module ddrc_opstate_bench;

  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr_i = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic       hw_idle_i = 1'b0;
  logic       dll_lock_i = 1'b1;
  logic [7:0] stat_o;
  logic       access_ready_o;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ddrc_opstate #(.LAT(LAT)) u_ddrc_opstate (
    .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr_i), .cmd_i(cmd_i),
    .hw_idle_i(hw_idle_i), .dll_lock_i(dll_lock_i),
    .stat_o(stat_o), .access_ready_o(access_ready_o)
  );

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic is_req(input logic [2:0] s);
    return (s == 3'd2) || (s == 3'd4) || (s == 3'd6) || (s == 3'd7);
  endfunction

  task automatic wait_stable();
    for (int i = 0; i < 60; i++) begin
      if (!is_req(stat_o[2:0])) break;
      tick();
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_wr_i = 1'b0; hw_idle_i = 1'b0; dll_lock_i = 1'b1;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic send(input logic [2:0] c);
    cmd_i = c; cmd_wr_i = 1'b1;
    tick();
    cmd_wr_i = 1'b0;
  endtask

  // Cycles the request state stays visible, counted at negedges.
  task automatic dwell(input logic [2:0] rq_state, output int n);
    n = 0;
    while (stat_o[2:0] == rq_state && n < 60) begin
      n++;
      tick();
    end
  endtask

  // Conditions: 0 init, 1 config, 2 access, 3 low power (sw), 4 low power (hw)
  task automatic goto_cond(input int w);
    do_reset();
    if (w >= 1) begin send(3'd1); wait_stable(); end
    if (w >= 2) begin send(3'd2); wait_stable(); end
    if (w == 3) begin send(3'd3); wait_stable(); end
    if (w == 4) begin hw_idle_i = 1'b1; tick(); wait_stable(); end
  endtask

  function automatic logic [7:0] cond_stat(input int w);
    case (w)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h03;
      3: return 8'h25;
      default: return 8'h15;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [2:0] exp_req;
    logic [7:0] exp_end;
    logic       legal;
    string      tag;

    // R1: reset state
    do_reset();
    chk("R1 status", stat_o, 8'h00);
    chk("R1 ready", {7'd0, access_ready_o}, 8'h00);

    // Sweep of every code in every settled condition (R2 via full-word compares)
    for (int w = 0; w < 5; w++) begin
      for (int c = 0; c < 8; c++) begin
        goto_cond(w);
        legal = 1'b0; exp_req = 3'd0; exp_end = 8'h00; tag = "R10";
        if (w == 0 && c == 1) begin legal = 1; exp_req = 3'd2; exp_end = 8'h01; tag = "R3"; end
        if (w == 1 && c == 2) begin legal = 1; exp_req = 3'd4; exp_end = 8'h03; tag = "R4"; end
        if (w == 2 && c == 3) begin legal = 1; exp_req = 3'd6; exp_end = 8'h25; tag = "R5"; end
        if (w == 3 && c == 4) begin legal = 1; exp_req = 3'd7; exp_end = 8'h03; tag = "R7"; end
        if (w == 4 && c == 4) tag = "R8";
        send(3'(c));
        if (legal) begin
          chk({tag, " request state"}, {5'd0, stat_o[2:0]}, {5'd0, exp_req});
          dwell(exp_req, n);
          chk("R11 dwell", 8'(n), 8'(LAT));
          chk({tag, " settled"}, stat_o, exp_end);
        end else begin
          chk({tag, " ignored"}, stat_o, cond_stat(w));
          repeat (LAT + 1) tick();
          chk({tag, " still ignored"}, stat_o, cond_stat(w));
        end
      end
    end

    // R6 and R8: idle entry and exit round trip
    goto_cond(2);
    hw_idle_i = 1'b1;
    tick();
    chk("R6 entry request", stat_o, 8'h16);
    wait_stable();
    chk("R6 low power", stat_o, 8'h15);
    hw_idle_i = 1'b0;
    tick();
    chk("R8 exit request", stat_o, 8'h17);
    wait_stable();
    chk("R7 trigger cleared", stat_o, 8'h03);

    // R5: sleep and idle together; software wins
    goto_cond(2);
    hw_idle_i = 1'b1;
    send(3'd3);
    chk("R5 sleep beats idle", stat_o, 8'h26);
    hw_idle_i = 1'b0;
    wait_stable();
    chk("R5 low power sw", stat_o, 8'h25);

    // R9: exit holds without DLL lock
    goto_cond(3);
    dll_lock_i = 1'b0;
    send(3'd4);
    repeat (LAT + 6) tick();
    chk("R9 exit held", stat_o, 8'h27);
    chk("R9 ready low", {7'd0, access_ready_o}, 8'h00);
    dll_lock_i = 1'b1;
    tick();
    chk("R9 access after lock", stat_o, 8'h03);
    chk("R9 ready high", {7'd0, access_ready_o}, 8'h01);
    dll_lock_i = 1'b0;
    #1;
    chk("R9 ready needs lock", {7'd0, access_ready_o}, 8'h00);
    dll_lock_i = 1'b1;

    // R10: command written during a request state is dropped
    do_reset();
    send(3'd1);
    send(3'd2);
    chk("R10 request kept", stat_o, 8'h02);
    wait_stable();
    chk("R10 ends in config", stat_o, 8'h01);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule